// File: doc/BRIEF.md
# Lamp Ballast Phase Sequencer

This block walks a half-bridge fluorescent-lamp ballast controller through its operating phases. Comparators outside the block turn the supply and lamp voltages into digital flags, and a slow clock generator outside the block sends timer ticks. From these the sequencer decides when the bridge may switch, when the timing capacitor may charge and when it must be held discharged. It also decides when the lamp is treated as lit, as failed or as powered down.

Start-up waits for the supply to rise above its start level. Preheat then runs for a fixed number of timer pulses. Ignition is allowed one pulse and is tried once only. A struck lamp moves the block to burn, and a lamp fault moves it to a latched hold. A supply drop below the stop level restarts the whole sequence from start-up. A power-down request latches the block off until the supply has gone through a full stop and start cycle. All flag inputs are synchronous to `clk`. The tick input is synchronized inside the block and counted once per rising edge.

Top module: `ballast_seq`

## Requirements
- R1: While reset is asserted, state_o reads 0 (reset phase), bridge_en_o is 0 and tmr_dis_o is 1. After reset is released the block moves to start-up (state_o = 1). The phase codes are 0 reset, 1 start-up, 2 preheat, 3 ignition, 4 burn, 5 hold, 6 power-down.
- R2: In start-up the bridge stays off and the block stays in that phase until sup_start_i is 1. It then enters preheat (2).
- R3: Preheat lasts exactly seven counted tick pulses. The seventh pulse moves the block to ignition (3) and the sixth does not.
- R4: In ignition, lamp_max_i = 0 means the lamp has struck, and the block enters burn (4).
- R5: If one tick pulse passes in ignition while lamp_max_i is still 1, the block enters hold (5). Hold then ignores further ticks, so preheat and ignition are not retried.
- R6: While lamp_fail_i is 1 in preheat, the pulse count is cleared and ticks are not counted. Preheat timing restarts from zero after the flag falls.
- R7: tmr_en_o is 1 only in preheat and ignition, and tmr_dis_o is its inverse.
- R8: bridge_en_o is 1 only in preheat, ignition and burn.
- R9: sup_stop_i = 1 in any phase moves the block to start-up on the next clock and clears the pulse count. This request has the highest priority.
- R10: pd_req_i = 1 in preheat, ignition, burn or hold moves the block to power-down (6). The block leaves power-down only through sup_stop_i. Dropping the request alone does not release it.
- R11: A tick held high for several clock cycles counts as one pulse.
- R12: In burn, lamp_fail_i = 1 moves the block to hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sup_start_i | input | 1 | Supply above start level |
| sup_stop_i | input | 1 | Supply below stop level |
| lamp_fail_i | input | 1 | Lamp voltage above fail level |
| lamp_max_i | input | 1 | Lamp voltage above maximum level (lamp not struck) |
| pd_req_i | input | 1 | Power-down request |
| tick_i | input | 1 | Slow timer clock, asynchronous |
| state_o | output | 3 | Current phase code |
| tmr_en_o | output | 1 | Timer running |
| tmr_dis_o | output | 1 | Timing capacitor discharge command |
| bridge_en_o | output | 1 | Half-bridge run enable |

## Verification
A directed pass drives the full phase sequence with short ticks and then with long ticks. The short ticks separate a count of six pulses from a count of seven. The long ticks show whether a tick held high for several cycles is counted once or many times. The directed pass also covers ignition both with and without a strike, which separates burn from the single-attempt hold. A lamp-fail pulse partway through preheat shows whether the count is cleared or only paused. Random sequences then mix ticks with toggling flags, so stop, power-down and restart land in every phase and at every count, and each result is compared with a bench model of the phase rules.

// File: rtl/ballast_pkg.sv
package ballast_pkg;
  localparam int PHASE_W = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_RESET   = 3'd0,
    PH_START   = 3'd1,
    PH_PREHEAT = 3'd2,
    PH_IGNITE  = 3'd3,
    PH_BURN    = 3'd4,
    PH_HOLD    = 3'd5,
    PH_PDOWN   = 3'd6
  } phase_e;
endpackage

// File: rtl/ballast_rst_sync.sv
module ballast_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ballast_tick_sync.sv
module ballast_tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic pulse_o
);
  logic [SYNC_STAGES:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[SYNC_STAGES-1:0], tick_i};
  end

  assign pulse_o = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
endmodule

// File: rtl/ballast_pulse_cnt.sv
module ballast_pulse_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = clr_i | inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ballast_fsm.sv
module ballast_fsm
  import ballast_pkg::*;
#(
  parameter int PH_PULSES  = 7,
  parameter int IGN_PULSES = 1,
  parameter int CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_start_i,
  input  logic             sup_stop_i,
  input  logic             lamp_fail_i,
  input  logic             lamp_max_i,
  input  logic             pd_req_i,
  input  logic             tick_pulse_i,
  input  logic [CNT_W-1:0] cnt_i,
  output phase_e           phase_o,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output logic             tmr_en_o,
  output logic             bridge_en_o
);
  localparam logic [CNT_W-1:0] PH_LAST  = CNT_W'(PH_PULSES - 1);
  localparam logic [CNT_W-1:0] IGN_LAST = CNT_W'(IGN_PULSES - 1);

  phase_e phase_q;
  phase_e phase_d;
  logic   restart;
  logic   active;

  always_comb begin
    active   = (phase_q == PH_PREHEAT) || (phase_q == PH_IGNITE) ||
               (phase_q == PH_BURN)    || (phase_q == PH_HOLD);
    tmr_en_o    = (phase_q == PH_PREHEAT) || (phase_q == PH_IGNITE);
    bridge_en_o = tmr_en_o || (phase_q == PH_BURN);
  end

  always_comb begin
    phase_d = phase_q;
    restart = 1'b0;
    case (phase_q)
      PH_RESET:   phase_d = PH_START;
      PH_START:   if (sup_start_i) phase_d = PH_PREHEAT;
      PH_PREHEAT: begin
        if (lamp_fail_i)                             restart = 1'b1;
        else if (tick_pulse_i && (cnt_i == PH_LAST)) phase_d = PH_IGNITE;
      end
      PH_IGNITE: begin
        if (!lamp_max_i)                               phase_d = PH_BURN;
        else if (tick_pulse_i && (cnt_i == IGN_LAST)) phase_d = PH_HOLD;
      end
      PH_BURN:    if (lamp_fail_i) phase_d = PH_HOLD;
      default:    phase_d = phase_q;
    endcase
    if (pd_req_i && active) phase_d = PH_PDOWN;
    if (sup_stop_i)         phase_d = PH_START;
  end

  always_comb begin
    cnt_clr_o = (phase_d != phase_q) || restart;
    cnt_inc_o = tick_pulse_i && tmr_en_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_RESET;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/ballast_seq.sv
module ballast_seq
  import ballast_pkg::*;
#(
  parameter int PH_PULSES   = 7,
  parameter int IGN_PULSES  = 1,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sup_start_i,
  input  logic               sup_stop_i,
  input  logic               lamp_fail_i,
  input  logic               lamp_max_i,
  input  logic               pd_req_i,
  input  logic               tick_i,
  output logic [PHASE_W-1:0] state_o,
  output logic               tmr_en_o,
  output logic               tmr_dis_o,
  output logic               bridge_en_o
);
  localparam int MAX_PULSES = (PH_PULSES > IGN_PULSES) ? PH_PULSES : IGN_PULSES;
  localparam int CNT_W      = $clog2(MAX_PULSES + 1);

  logic             rst_sync_n;
  logic             tick_pulse;
  logic             cnt_clr;
  logic             cnt_inc;
  logic [CNT_W-1:0] cnt_q;
  phase_e           phase_q;
  logic             tmr_en;

  ballast_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ballast_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_i  (tick_i),
    .pulse_o (tick_pulse)
  );

  ballast_pulse_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt_q)
  );

  ballast_fsm #(
    .PH_PULSES  (PH_PULSES),
    .IGN_PULSES (IGN_PULSES),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .sup_start_i  (sup_start_i),
    .sup_stop_i   (sup_stop_i),
    .lamp_fail_i  (lamp_fail_i),
    .lamp_max_i   (lamp_max_i),
    .pd_req_i     (pd_req_i),
    .tick_pulse_i (tick_pulse),
    .cnt_i        (cnt_q),
    .phase_o      (phase_q),
    .cnt_clr_o    (cnt_clr),
    .cnt_inc_o    (cnt_inc),
    .tmr_en_o     (tmr_en),
    .bridge_en_o  (bridge_en_o)
  );

  assign state_o   = phase_q;
  assign tmr_en_o  = tmr_en;
  assign tmr_dis_o = ~tmr_en;
endmodule

// File: rtl/ballast_seq_chk.sv
module ballast_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sup_start_i,
  input logic       sup_stop_i,
  input logic       pd_req_i,
  input logic [2:0] state_o,
  input logic       tmr_en_o,
  input logic       bridge_en_o
);
  logic active;
  assign active = (state_o >= 3'd2) && (state_o <= 3'd5);

  a_r1_leave_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0) |=> (state_o == 3'd1));

  a_r2_wait_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && !sup_start_i) |=> (state_o == 3'd1));

  a_r3_ignite_from_preheat: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && $past(state_o) != 3'd3) |-> ($past(state_o) == 3'd2));

  a_r5_hold_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && !sup_stop_i && !pd_req_i) |=> (state_o == 3'd5));

  a_r7_timer_starts_in_preheat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_en_o) |-> (state_o == 3'd2));

  a_r8_bridge_starts_from_startup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bridge_en_o) |-> ($past(state_o) == 3'd1));

  a_r9_stop_to_startup: assert property (@(posedge clk) disable iff (!rst_n)
    sup_stop_i |=> (state_o == 3'd1));

  a_r10_enter_pdown: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req_i && active && !sup_stop_i) |=> (state_o == 3'd6));

  a_r10_pdown_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd6 && !sup_stop_i) |=> (state_o == 3'd6));
endmodule

bind ballast_seq ballast_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .sup_start_i (sup_start_i),
  .sup_stop_i  (sup_stop_i),
  .pd_req_i    (pd_req_i),
  .state_o     (state_o),
  .tmr_en_o    (tmr_en_o),
  .bridge_en_o (bridge_en_o)
);

// File: tb/ballast_seq_tb_top.sv
module ballast_seq_tb_top;
  localparam int S_RST = 0, S_STA = 1, S_PRE = 2, S_IGN = 3,
                 S_BRN = 4, S_HLD = 5, S_PDN = 6;
  localparam int PRE_N = 7;
  localparam int IGN_N = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sup_start = 1'b0, sup_stop = 1'b0, lamp_fail = 1'b0;
  logic       lamp_max = 1'b1, pd_req = 1'b0, tick = 1'b0;
  logic [2:0] state;
  logic       tmr_en, tmr_dis, bridge_en;

  int total = 0;
  int bad   = 0;
  int m_st  = S_RST;
  int m_cnt = 0;

  always #2 clk = ~clk;

  ballast_seq dut_i (
    .clk (clk), .rst_n (rst_n),
    .sup_start_i (sup_start), .sup_stop_i (sup_stop),
    .lamp_fail_i (lamp_fail), .lamp_max_i (lamp_max),
    .pd_req_i (pd_req), .tick_i (tick),
    .state_o (state), .tmr_en_o (tmr_en), .tmr_dis_o (tmr_dis),
    .bridge_en_o (bridge_en)
  );

  function automatic bit exp_tmr(int s);
    return (s == S_PRE) || (s == S_IGN);
  endfunction

  function automatic bit exp_bridge(int s);
    return (s == S_PRE) || (s == S_IGN) || (s == S_BRN);
  endfunction

  // Phase rules as written in the requirements, one clock per call.
  function automatic void m_step(bit tk);
    int nx = m_st;
    bit rs = 1'b0;
    case (m_st)
      S_RST: nx = S_STA;
      S_STA: if (sup_start) nx = S_PRE;
      S_PRE: if (lamp_fail) rs = 1'b1; else if (tk && m_cnt == PRE_N - 1) nx = S_IGN;
      S_IGN: if (!lamp_max) nx = S_BRN; else if (tk && m_cnt == IGN_N - 1) nx = S_HLD;
      S_BRN: if (lamp_fail) nx = S_HLD;
      default: nx = m_st;
    endcase
    if (pd_req && m_st >= S_PRE && m_st <= S_HLD) nx = S_PDN;
    if (sup_stop) nx = S_STA;
    if (nx != m_st || rs) m_cnt = 0;
    else if (tk && exp_tmr(m_st)) m_cnt++;
    m_st = nx;
  endfunction

  function automatic void m_settle();
    for (int i = 0; i < 8; i++) m_step(1'b0);
  endfunction

  task automatic check(string req, int want);
    total++;
    if (state !== 3'(want) || bridge_en !== exp_bridge(want) ||
        tmr_en !== exp_tmr(want) || tmr_dis !== !exp_tmr(want)) begin
      bad++;
      $display("FAIL %s: state=%0d bridge=%b tmr=%b dis=%b expected state=%0d bridge=%b tmr=%b dis=%b",
               req, state, bridge_en, tmr_en, tmr_dis, want,
               exp_bridge(want), exp_tmr(want), !exp_tmr(want));
    end
  endtask

  task automatic apply();
    repeat (8) @(negedge clk);
    m_settle();
  endtask

  task automatic pulse_tick(int hi);
    @(negedge clk);
    tick = 1'b1;
    repeat (hi) @(negedge clk);
    tick = 1'b0;
    repeat (6) @(negedge clk);
    m_step(1'b1);
    m_settle();
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", S_RST);
    rst_n = 1'b1;
    apply();
    check("R1 release", S_STA);
    check("R2 wait start", S_STA);
    sup_start = 1'b1; apply();
    check("R2 enter preheat", S_PRE);
    for (int i = 0; i < 6; i++) pulse_tick(1);
    check("R3 six pulses", S_PRE);
    pulse_tick(1);
    check("R3 seventh pulse", S_IGN);
    pulse_tick(1);
    check("R5 ignition timeout", S_HLD);
    pulse_tick(1); pulse_tick(1);
    check("R5 no retry", S_HLD);
    sup_stop = 1'b1; apply();
    check("R9 stop from hold", S_STA);
    sup_stop = 1'b0; apply();
    check("R2 restart preheat", S_PRE);
    for (int i = 0; i < 3; i++) pulse_tick(1);
    lamp_fail = 1'b1; apply();
    pulse_tick(1);
    check("R6 tick ignored while fail", S_PRE);
    lamp_fail = 1'b0; apply();
    for (int i = 0; i < 6; i++) pulse_tick(5);
    check("R6 R11 count restarted, long ticks", S_PRE);
    pulse_tick(5);
    check("R11 seventh long pulse", S_IGN);
    check("R7 timer in ignition", S_IGN);
    lamp_max = 1'b0; apply();
    check("R4 strike", S_BRN);
    pulse_tick(1);
    check("R8 burn ignores tick", S_BRN);
    lamp_fail = 1'b1; apply();
    check("R12 burn to hold", S_HLD);
    lamp_fail = 1'b0; lamp_max = 1'b1;
    pd_req = 1'b1; apply();
    check("R10 power-down", S_PDN);
    pd_req = 1'b0; apply();
    check("R10 stays after request drop", S_PDN);
    sup_stop = 1'b1; apply();
    check("R9 R10 stop releases", S_STA);
    sup_stop = 1'b0; apply();
    check("R2 start again", S_PRE);
    pd_req = 1'b1; apply();
    check("R10 from preheat", S_PDN);
    pd_req = 1'b0; apply();

    void'($urandom(32'd20240611));
    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom % 12);
      if (r < 6) begin
        pulse_tick(1 + int'($urandom % 4));
        check("R3 R5 R11 random tick", m_st);
      end else if (r == 6) begin
        lamp_fail = ~lamp_fail; apply();
        check("R6 R12 random lamp fail", m_st);
      end else if (r == 7) begin
        lamp_max = ~lamp_max; apply();
        check("R4 random strike", m_st);
      end else if (r == 8) begin
        if ($urandom % 3 == 0) pd_req = 1'b1; else pd_req = 1'b0;
        apply();
        check("R10 random power-down", m_st);
      end else if (r == 9) begin
        sup_stop = 1'b1; apply();
        check("R9 random stop", m_st);
        sup_stop = 1'b0; apply();
        check("R9 random stop release", m_st);
      end else begin
        sup_start = ($urandom % 4 != 0); apply();
        check("R2 R8 random start flag", m_st);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule